// File: doc/BRIEF.md
# Quadrant Direction FIFO Status Generator

This block produces the full, almost-full, empty and almost-empty flags for a dual-clock FIFO whose read and write pointers have exactly as many bits as the address. Equal pointers can mean an empty FIFO or a full one. A direction flag settles which one it is. The flag is set once the write pointer approaches the read pointer from behind, which means the FIFO is filling. It is cleared once the write pointer has just moved ahead of the read pointer, which means the FIFO is draining.

The pointers arrive Gray coded and have already been synchronized into the domain that uses them. The write half sees its own pointer and a copy of the read pointer. The read half sees its own pointer and a copy of the write pointer. Each half keeps its own direction flag. It registers its flags on its own clock.

Because the synchronized copies lag behind, the occupancy that each half works from is never better than the true occupancy. As a result, full and almost-full may assert early, and empty and almost-empty may stay asserted late, but neither fails to appear when the FIFO really reaches that state.

Top module: `fifo_quad_status`

## Requirements
- R1: Pointers are Gray coded. The quadrant of a pointer is its two most significant Gray bits, and the quadrants follow the order 00, 01, 11, 10 as the pointer counts up.
- R2: When the write quadrant is one step before the read quadrant in that order, the direction flag of that domain is set (the FIFO is filling).
- R3: When the write quadrant is one step after the read quadrant, the direction flag is cleared (the FIFO is draining). In every other case the flag holds.
- R4: On the write clock edge after the inputs show equal pointers with the updated direction flag set, full is high. Otherwise full is low.
- R5: On the read clock edge after the inputs show equal pointers with the updated direction flag clear, empty is high. Otherwise empty is low.
- R6: Occupancy is (write − read) modulo 2^AW. It is taken as 2^AW when the pointers are equal and the direction flag is set. afull is registered high when the write-domain occupancy is at least three quarters of the depth.
- R7: aempty is registered high when the read-domain occupancy is at most one quarter of the depth.
- R8: Reset clears the direction flags. While a reset is active, full and afull are low and empty and aempty are high. After reset, equal pointers read as empty, whatever their value.
- R9: The flags are conservative. full implies afull, and empty implies aempty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wptr_g | input | AW | Write pointer, Gray coded |
| rptr_wg | input | AW | Read pointer synchronized into the write domain, Gray coded |
| full | output | 1 | FIFO full, write domain |
| afull | output | 1 | Occupancy at or above three quarters, write domain |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rptr_g | input | AW | Read pointer, Gray coded |
| wptr_rg | input | AW | Write pointer synchronized into the read domain, Gray coded |
| empty | output | 1 | FIFO empty, read domain |
| aempty | output | 1 | Occupancy at or below one quarter, read domain |

## Verification
The assertions check the following on every cycle:
- In each domain, the direction flag follows the adjacent-quadrant rules.
- full is always accompanied by afull, and empty by aempty.
- empty rises only after equal pointers.

The bench's scenarios are needed for the rest:
- The exact cycle in which each flag changes while filling, draining and mixed traffic run with two-cycle-stale pointer copies.
- That equal pointers can mean either full or empty.
- That a reset with equal pointers at a nonzero value reads as empty.

// File: rtl/fifo_quad_status.sv
module fifo_quad_status #(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic [AW-1:0] wptr_g,
  input  logic [AW-1:0] rptr_wg,
  output logic          full,
  output logic          afull,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [AW-1:0] rptr_g,
  input  logic [AW-1:0] wptr_rg,
  output logic          empty,
  output logic          aempty
);

  localparam int       DEPTH = 1 << AW;
  localparam logic [AW:0] HI_MARK = (AW+1)'((3 * DEPTH) / 4);
  localparam logic [AW:0] LO_MARK = (AW+1)'(DEPTH / 4);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic dir_upd(input logic [1:0] wq, input logic [1:0] rq, input logic cur);
    if (wq + 2'd1 == rq)      return 1'b1;
    else if (rq + 2'd1 == wq) return 1'b0;
    else                      return cur;
  endfunction

  function automatic logic [AW:0] occ(input logic [AW-1:0] wb, input logic [AW-1:0] rb, input logic d);
    logic [AW-1:0] diff;
    diff = wb - rb;
    if (diff == '0 && d) return (AW+1)'(DEPTH);
    return {1'b0, diff};
  endfunction

  // write domain
  logic [AW-1:0] w_wb, w_rb;
  logic          w_dir, w_dir_n;
  logic [AW:0]   w_occ;

  assign w_wb    = g2b(wptr_g);
  assign w_rb    = g2b(rptr_wg);
  assign w_dir_n = dir_upd(w_wb[AW-1:AW-2], w_rb[AW-1:AW-2], w_dir);
  assign w_occ   = occ(w_wb, w_rb, w_dir_n);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_dir <= 1'b0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      w_dir <= w_dir_n;
      full  <= (w_wb == w_rb) && w_dir_n;
      afull <= w_occ >= HI_MARK;
    end
  end

  a_r2_wdir_set: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_wb[AW-1:AW-2] + 2'd1 == w_rb[AW-1:AW-2]) |=> w_dir);
  a_r3_wdir_clear: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_rb[AW-1:AW-2] + 2'd1 == w_wb[AW-1:AW-2]) |=> !w_dir);
  a_r9_full_has_afull: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> afull);

  // read domain
  logic [AW-1:0] r_wb, r_rb;
  logic          r_dir, r_dir_n;
  logic [AW:0]   r_occ;

  assign r_wb    = g2b(wptr_rg);
  assign r_rb    = g2b(rptr_g);
  assign r_dir_n = dir_upd(r_wb[AW-1:AW-2], r_rb[AW-1:AW-2], r_dir);
  assign r_occ   = occ(r_wb, r_rb, r_dir_n);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      r_dir  <= 1'b0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      r_dir  <= r_dir_n;
      empty  <= (r_wb == r_rb) && !r_dir_n;
      aempty <= r_occ <= LO_MARK;
    end
  end

  a_r2_rdir_set: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_wb[AW-1:AW-2] + 2'd1 == r_rb[AW-1:AW-2]) |=> r_dir);
  a_r3_rdir_clear: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_rb[AW-1:AW-2] + 2'd1 == r_wb[AW-1:AW-2]) |=> !r_dir);
  a_r9_empty_has_aempty: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> aempty);
  a_r5_empty_needs_equal: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(empty) |-> $past(r_wb == r_rb));

endmodule

// File: tb/test_fifo_quad_status.sv
`timescale 1ns/1ps
module test_fifo_quad_status;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] wptr_g, rptr_wg, rptr_g, wptr_rg;
  logic full, afull, empty, aempty;

  int checks = 0, fails = 0;
  int wp = 0, wph1 = 0, wph2 = 0;
  int rp = 0, rph1 = 0, rph2 = 0;

  always #2 clk = ~clk;

  fifo_quad_status #(.AW(AW)) i_fifo_quad_status (
    .wclk(clk), .wrst_n(rst_n), .wptr_g(wptr_g), .rptr_wg(rptr_wg),
    .full(full), .afull(afull),
    .rclk(clk), .rrst_n(rst_n), .rptr_g(rptr_g), .wptr_rg(wptr_rg),
    .empty(empty), .aempty(aempty));

  // R1: Gray coding of the pointers
  function automatic logic [AW-1:0] gray(input int v);
    logic [AW-1:0] b;
    b = v[AW-1:0];
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (wp=%0d rp=%0d)", req, act, exp, wp, rp);
    end
  endtask

  task automatic drive();
    wptr_g  = gray(wp);
    rptr_wg = gray(rph2);
    rptr_g  = gray(rp);
    wptr_rg = gray(wph2);
  endtask

  // mode 0 push only, 1 pop only, 2 random, 3 idle
  task automatic step(input int mode);
    int wv, rv;
    bit push, pop;
    @(negedge clk);
    wv = wp - rph2;
    rv = wph2 - rp;
    chk("R4 full (R2 direction set)", full, wv == D);
    chk("R5 empty (R3 direction clear)", empty, rv == 0);
    chk("R6 afull", afull, wv >= (3 * D) / 4);
    chk("R7 aempty", aempty, rv <= D / 4);
    chk("R9 full implies afull", !full || afull, 1'b1);
    push = (mode == 0 || (mode == 2 && ($urandom % 2 == 1))) && (wp - rph1 < D);
    pop  = (mode == 1 || (mode == 2 && ($urandom % 2 == 1))) && (wph1 - rp > 0);
    wph2 = wph1; wph1 = wp;
    rph2 = rph1; rph1 = rp;
    if (push) wp++;
    if (pop)  rp++;
    drive();
  endtask

  task automatic do_reset(input int start);
    @(negedge clk);
    rst_n = 1'b0;
    wp = start; wph1 = start; wph2 = start;
    rp = start; rph1 = start; rph2 = start;
    drive();
    @(negedge clk);
    @(negedge clk);
    chk("R8 full low in reset", full, 1'b0);
    chk("R8 afull low in reset", afull, 1'b0);
    chk("R8 empty high in reset", empty, 1'b1);
    chk("R8 aempty high in reset", aempty, 1'b1);
    rst_n = 1'b1;
  endtask

  initial begin
    wptr_g = '0; rptr_wg = '0; rptr_g = '0; wptr_rg = '0;
    do_reset(0);
    for (int i = 0; i < 30; i++) step(0);
    for (int i = 0; i < 10; i++) step(3);
    for (int i = 0; i < 30; i++) step(1);
    for (int i = 0; i < 10; i++) step(3);
    for (int i = 0; i < 300; i++) step(2);
    // R8: nonzero equal pointers after reset must read as empty
    do_reset(5);
    for (int i = 0; i < 3; i++) step(3);
    for (int i = 0; i < 25; i++) step(0);
    for (int i = 0; i < 60; i++) step(2);
    for (int i = 0; i < 30; i++) step(1);
    for (int i = 0; i < 30; i++) step(0);
    for (int i = 0; i < 30; i++) step(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule